// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This block sits between a processor's register file and a byte-addressed 32-bit data bus. For each load or store it adds or subtracts an offset to a base register value. It picks the access address from the indexing mode and decides whether the sum goes back to the base register. It also drives a word-aligned bus address with a byte-enable mask.

For stores, the block copies the store data into every byte lane that matches the access size. For loads, it captures the lane selection when the request is issued. One cycle later it extracts the addressed byte, halfword or word from the returned bus word and zero-extends it.

Byte order within the bus word follows an endianness input. The block samples that input at the first clock edge after reset ends and holds it from then on, so the order cannot change while the system runs.

Top module: `ldst_lane_unit`

## Requirements
- R1: With `pre_idx`=1 and `wb_req`=0, the access uses base+offset (or base-offset) and `base_we` stays low.
- R2: With `pre_idx`=1 and `wb_req`=1, the access uses the computed sum, `base_we` is high and `base_new` equals that same sum.
- R3: With `pre_idx`=0, the access uses the unmodified base, and `base_we` is high whatever `wb_req` holds, with `base_new` = base±offset.
- R4: With `off_sub`=1 the offset is subtracted from the base, modulo 2^32.
- R5: `mem_addr` is the computed byte address with bits 1:0 forced to zero.
- R6: Little-endian lanes, where `mem_be` bit i enables data bits 8i+7:8i. A byte access at low address bits a enables bit a. A halfword enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1.
- R7: Big-endian lanes. A byte access at low address bits a enables bit 3-a. A halfword enables 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1.
- R8: A store (`is_load`=0) raises `mem_we`. `mem_wdata` repeats `st_data[7:0]` in all four lanes for a byte store and `st_data[15:0]` in both halves for a halfword store. For a word store it carries `st_data` unchanged.
- R9: A load issued in one cycle shows its result on `ld_data` in the next cycle, taken from `rd_word` that cycle. The result is the addressed byte or halfword (lanes per R6/R7) zero-extended to 32 bits, or the whole word.
- R10: The endianness (`be_mode`=1 big, 0 little) is captured at the first rising edge after `rst_n` goes high. Later changes of `be_mode` have no effect until the next reset.
- R11: While `acc_valid` is low, `mem_be` is 0 and `mem_we` and `base_we` are low.
- R12: `acc_size` encodes 2'b00 byte, 2'b01 halfword, 2'b10 word. The value 2'b11 is handled as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load/store is issued this cycle |
| is_load | input | 1 | 1 load, 0 store |
| pre_idx | input | 1 | 1 access at base±offset, 0 access at base (post-index) |
| wb_req | input | 1 | Request base writeback in pre-index mode |
| off_sub | input | 1 | Subtract the offset instead of adding it |
| acc_size | input | 2 | Access size code (R12) |
| base_val | input | 32 | Base register value |
| offset_val | input | 32 | Immediate or register offset |
| be_mode | input | 1 | Endianness select, sampled after reset |
| st_data | input | 32 | Store data, right-aligned |
| rd_word | input | 32 | Bus read word, one cycle after the load request |
| mem_addr | output | 32 | Word-aligned bus address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_we | output | 1 | Store strobe |
| ld_data | output | 32 | Extracted, zero-extended load data |
| base_new | output | 32 | Updated base value |
| base_we | output | 1 | Base register writeback strobe |

## Verification
On every cycle the assertions check the following:
- Post-index accesses always use the raw base and always write back.
- A byte access enables exactly one lane, and a halfword access enables one aligned lane pair.
- An idle cycle enables nothing.
- Extracted byte loads have clear upper bits.
- The captured endianness never moves once locked.

Only the bench scenarios can show the exact lane numbering in each byte order, the replicated store patterns, subtraction wrapping below zero and the one-cycle alignment of load data with the returned word. They also show that a late change of `be_mode` is ignored.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              pre_idx,
  input  logic              wb_req,
  input  logic              off_sub,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] offset_val,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] base_new,
  output logic              base_we
);
  logic [ADDR_W-1:0] off_eff;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    off_eff  = off_sub ? (~offset_val + ADDR_W'(1)) : offset_val;
    sum      = base_val + off_eff;
    acc_addr = pre_idx ? sum : base_val;
    base_new = sum;
    // post-index always updates the base; pre-index only on request
    base_we  = acc_valid & (~pre_idx | wb_req);
  end

  assert_post_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !pre_idx) |-> (base_we && acc_addr == base_val));

  assert_pre_nowb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && pre_idx && !wb_req) |-> !base_we);
endmodule

// File: rtl/ldst_lane_steer.sv
module ldst_lane_steer
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              is_load,
  input  acc_size_e         acc_size,
  input  logic [1:0]        addr_lo,
  input  logic              big_end,
  input  logic [BUS_W-1:0]  st_data,
  output logic [LANES-1:0]  mem_be,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic              mem_we,
  output logic [LANE_W-1:0] byte_lane,
  output logic              half_hi
);
  logic [LANES-1:0] be_raw;

  always_comb begin
    byte_lane = big_end ? (LANE_W'(LANES - 1) - addr_lo) : addr_lo;
    half_hi   = big_end ? ~addr_lo[1] : addr_lo[1];
    unique case (acc_size)
      SZ_BYTE: be_raw = LANES'(1) << byte_lane;
      SZ_HALF: be_raw = half_hi ? 4'b1100 : 4'b0011;
      default: be_raw = '1;
    endcase
    mem_be = acc_valid ? be_raw : '0;
    mem_we = acc_valid & ~is_load;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (acc_size)
        SZ_BYTE: mem_wdata[8*g +: 8] = st_data[7:0];
        SZ_HALF: mem_wdata[8*g +: 8] = st_data[8*(g%2) +: 8];
        default: mem_wdata[8*g +: 8] = st_data[8*g +: 8];
      endcase
    end
  end

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == SZ_BYTE) |-> ($countones(mem_be) == 1));

  assert_half_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size == SZ_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));
endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  acc_size_e         req_size,
  input  logic [LANE_W-1:0] req_lane,
  input  logic              req_half_hi,
  input  logic [BUS_W-1:0]  rd_word,
  output logic [BUS_W-1:0]  ld_data
);
  acc_size_e         size_q, size_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              hhi_q,  hhi_d;
  logic [BUS_W-1:0]  shifted;

  always_comb begin
    size_d = size_q;
    lane_d = lane_q;
    hhi_d  = hhi_q;
    if (cap_en) begin
      size_d = req_size;
      lane_d = req_lane;
      hhi_d  = req_half_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_WORD;
      lane_q <= '0;
      hhi_q  <= 1'b0;
    end else begin
      size_q <= size_d;
      lane_q <= lane_d;
      hhi_q  <= hhi_d;
    end
  end

  always_comb begin
    shifted = rd_word >> {lane_q, 3'b000};
    unique case (size_q)
      SZ_BYTE: ld_data = {24'd0, shifted[7:0]};
      SZ_HALF: ld_data = {16'd0, hhi_q ? rd_word[31:16] : rd_word[15:0]};
      default: ld_data = rd_word;
    endcase
  end

  assert_zext_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == SZ_BYTE) |-> (ld_data[31:8] == 24'd0));
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              is_load,
  input  logic              pre_idx,
  input  logic              wb_req,
  input  logic              off_sub,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] offset_val,
  input  logic              be_mode,
  input  logic [BUS_W-1:0]  st_data,
  input  logic [BUS_W-1:0]  rd_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic              mem_we,
  output logic [BUS_W-1:0]  ld_data,
  output logic [ADDR_W-1:0] base_new,
  output logic              base_we
);
  localparam int ALIGN_B = LANE_W;

  logic              be_q, be_d;
  logic              lock_q, lock_d;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANE_W-1:0] byte_lane;
  logic              half_hi;
  acc_size_e         size_e;

  assign size_e = acc_size_e'(acc_size);

  // endianness latch: loads once after reset, then holds
  always_comb begin
    be_d   = be_q;
    lock_d = lock_q;
    if (!lock_q) begin
      be_d   = be_mode;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q   <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      be_q   <= be_d;
      lock_q <= lock_d;
    end
  end

  ldst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .pre_idx    (pre_idx),
    .wb_req     (wb_req),
    .off_sub    (off_sub),
    .base_val   (base_val),
    .offset_val (offset_val),
    .acc_addr   (acc_addr),
    .base_new   (base_new),
    .base_we    (base_we)
  );

  assign mem_addr = {acc_addr[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};

  ldst_lane_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .is_load   (is_load),
    .acc_size  (size_e),
    .addr_lo   (acc_addr[1:0]),
    .big_end   (be_q),
    .st_data   (st_data),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .byte_lane (byte_lane),
    .half_hi   (half_hi)
  );

  ldst_load_extract u_extract (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (acc_valid & is_load),
    .req_size    (size_e),
    .req_lane    (byte_lane),
    .req_half_hi (half_hi),
    .rd_word     (rd_word),
    .ld_data     (ld_data)
  );

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> $stable(be_q));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (mem_be == '0 && !mem_we && !base_we));
endmodule

// File: tb/ldst_lane_unit_tb_top.sv
module ldst_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, is_load, pre_idx, wb_req, off_sub, be_mode;
  logic [1:0]  acc_size;
  logic [31:0] base_val, offset_val, st_data, rd_word;
  logic [31:0] mem_addr, mem_wdata, ld_data, base_new;
  logic [3:0]  mem_be;
  logic        mem_we, base_we;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ldst_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .is_load(is_load),
    .pre_idx(pre_idx), .wb_req(wb_req), .off_sub(off_sub), .acc_size(acc_size),
    .base_val(base_val), .offset_val(offset_val), .be_mode(be_mode),
    .st_data(st_data), .rd_word(rd_word), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .ld_data(ld_data),
    .base_new(base_new), .base_we(base_we)
  );

  typedef struct packed {
    logic        pre;
    logic        wb;
    logic        sub;
    logic [1:0]  sz;
    logic [31:0] base;
    logic [31:0] off;
    logic [31:0] sd;
    logic [31:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic        e_bwe;
    logic [31:0] e_new;
  } vec_t;

  localparam int NV = 7;
  // little-endian store vectors
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1,1'b0,1'b0,2'd2,32'h1000,32'h4, 32'hA1B2C3D4,32'h1004,    4'hF,32'hA1B2C3D4,1'b0,32'h1004},
    '{1'b1,1'b1,1'b1,2'd1,32'h2000,32'h6, 32'h1234BEEF,32'h1FF8,    4'hC,32'hBEEFBEEF,1'b1,32'h1FFA},
    '{1'b0,1'b0,1'b0,2'd0,32'h303, 32'h10,32'hFFFFFF5A,32'h300,     4'h8,32'h5A5A5A5A,1'b1,32'h313},
    '{1'b0,1'b1,1'b1,2'd0,32'h101, 32'h1, 32'h00000077,32'h100,     4'h2,32'h77777777,1'b1,32'h100},
    '{1'b1,1'b0,1'b0,2'd1,32'h40,  32'h0, 32'h00001234,32'h40,      4'h3,32'h12341234,1'b0,32'h40},
    '{1'b1,1'b1,1'b1,2'd2,32'h0,   32'h4, 32'hCAFEF00D,32'hFFFFFFFC,4'hF,32'hCAFEF00D,1'b1,32'hFFFFFFFC},
    '{1'b1,1'b0,1'b0,2'd3,32'h10,  32'h2, 32'h87654321,32'h10,      4'hF,32'h87654321,1'b0,32'h12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; is_load = 0; pre_idx = 1; wb_req = 0; off_sub = 0;
    acc_size = 2'd2; base_val = 0; offset_val = 0; st_data = 0; rd_word = 0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 0; be_mode = mode; idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);   // endianness captured at the edge in between
  endtask

  // byte-enable probe at given byte address, size code sz
  task automatic probe_be(input string tag, input logic [1:0] sz,
                          input logic [31:0] addr, input logic [3:0] exp);
    @(negedge clk);
    acc_valid = 1; is_load = 0; pre_idx = 1; wb_req = 0; off_sub = 0;
    acc_size = sz; base_val = addr; offset_val = 0;
    #2 chk(tag, {28'd0, mem_be}, {28'd0, exp});
  endtask

  // issue load, return word in following cycle, check extracted data
  task automatic do_load(input string tag, input logic [1:0] sz, input logic [31:0] addr,
                         input logic [31:0] word, input logic [31:0] exp);
    @(negedge clk);
    acc_valid = 1; is_load = 1; pre_idx = 1; wb_req = 0; off_sub = 0;
    acc_size = sz; base_val = addr; offset_val = 0;
    #2 chk({tag, " no store strobe"}, {31'd0, mem_we}, 32'd0);
    @(posedge clk);
    #1 acc_valid = 0; rd_word = word;
    #2 chk(tag, ld_data, exp);
  endtask

  initial begin
    rst_n = 0; be_mode = 0; idle_inputs();
    #1;
    // reset state, R11: nothing enabled
    chk("R11 reset mem_be", {28'd0, mem_be}, 32'd0);
    chk("R11 reset base_we", {31'd0, base_we}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // vector table in little-endian mode: R1 R2 R3 R4 R5 R6 R8 R12
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      acc_valid = 1; is_load = 0;
      pre_idx = VECS[i].pre; wb_req = VECS[i].wb; off_sub = VECS[i].sub;
      acc_size = VECS[i].sz; base_val = VECS[i].base; offset_val = VECS[i].off;
      st_data = VECS[i].sd;
      #2;
      chk($sformatf("R1/R3/R5 vec%0d mem_addr", i), mem_addr, VECS[i].e_addr);
      chk($sformatf("R6/R12 vec%0d mem_be", i), {28'd0, mem_be}, {28'd0, VECS[i].e_be});
      chk($sformatf("R8 vec%0d mem_wdata", i), mem_wdata, VECS[i].e_wd);
      chk($sformatf("R8 vec%0d mem_we", i), {31'd0, mem_we}, 32'd1);
      chk($sformatf("R2/R3 vec%0d base_we", i), {31'd0, base_we}, {31'd0, VECS[i].e_bwe});
      chk($sformatf("R2/R4 vec%0d base_new", i), base_new, VECS[i].e_new);
    end

    // R11: idle cycle with live operands
    @(negedge clk);
    acc_valid = 0; pre_idx = 0; base_val = 32'h55;
    #2;
    chk("R11 idle mem_be", {28'd0, mem_be}, 32'd0);
    chk("R11 idle mem_we", {31'd0, mem_we}, 32'd0);
    chk("R11 idle base_we", {31'd0, base_we}, 32'd0);

    // R9 little-endian loads
    do_load("R9 LE byte @201", 2'd0, 32'h201, 32'h11223344, 32'h33);
    do_load("R9 LE half @202", 2'd1, 32'h202, 32'h11223344, 32'h1122);
    do_load("R9 LE half @200", 2'd1, 32'h200, 32'hA5A58001, 32'h8001);
    do_load("R9 LE word @204", 2'd2, 32'h204, 32'hDEADBEEF, 32'hDEADBEEF);

    // R10: a late mode change must not alter lane order
    @(negedge clk);
    be_mode = 1;
    repeat (2) @(negedge clk);
    probe_be("R10 LE kept byte @200", 2'd0, 32'h200, 4'h1);
    probe_be("R6 LE byte @202", 2'd0, 32'h202, 4'h4);

    // big-endian phase
    do_reset(1'b1);
    probe_be("R7 BE byte @200", 2'd0, 32'h200, 4'h8);
    probe_be("R7 BE byte @203", 2'd0, 32'h203, 4'h1);
    probe_be("R7 BE half @200", 2'd1, 32'h200, 4'hC);
    probe_be("R7 BE half @202", 2'd1, 32'h202, 4'h3);
    probe_be("R12 BE word", 2'd2, 32'h200, 4'hF);
    do_load("R9 BE byte @201", 2'd0, 32'h201, 32'h11223344, 32'h22);
    do_load("R9 BE byte @203", 2'd0, 32'h203, 32'h11223344, 32'h44);
    do_load("R9 BE half @200", 2'd1, 32'h200, 32'h11223344, 32'h1122);
    do_load("R9 BE half @202", 2'd1, 32'h202, 32'h11223344, 32'h3344);
    @(negedge clk);
    be_mode = 0;
    repeat (2) @(negedge clk);
    probe_be("R10 BE kept byte @200", 2'd0, 32'h200, 4'h8);

    // BE store replication still uses low bits
    @(negedge clk);
    acc_valid = 1; is_load = 0; acc_size = 2'd1; base_val = 32'h202; st_data = 32'hFFFF0A0B;
    #2 chk("R8 BE half wdata", mem_wdata, 32'h0A0B0A0B);

    @(negedge clk);
    idle_inputs();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule